// File: doc/BRIEF.md
# ECP Host Port Handshake Engine

This block is the host end of an extended-capability parallel port. Software writes command bytes and data bytes into a forward FIFO through a small register window. The engine sends each byte to the peripheral with a strobe/busy handshake. A host-driven acknowledge line (`hostack`) carries a tag with each byte: low for a command, high for data. In the reverse direction the same acknowledge line becomes the host's flow-control reply. It is interlocked against the peripheral's `nack` strobe, and each byte received goes into a reverse FIFO that software drains.

The direction follows the `ninit` level: high is forward and low is reverse. A turnaround happens only from an idle handshake. Before a turn to reverse, the forward FIFO must also be empty. The host releases the shared data bus before it drops `ninit`, and it takes the bus back only after it has raised `ninit` again. The peripheral can pull `nfault` low to ask for a reverse transfer. This only sets a request flag and the `irq` output; software chooses whether to turn the port.

Register offsets from the port base: `0x000` is the command FIFO and `0x400` is the data FIFO, both only in mode `3'b011` (ECP). `0x402` is the control/status register, which works in every mode. An access is dropped whenever `dma_act` is high. Each handshake wait is limited by `tmo_cycles`, and a timeout sets an error flag.

Top module: `ecp_host_engine`

## Requirements
- R1: In ECP mode, a write to `0x000` sends the byte with `hostack` low and a write to `0x400` sends it with `hostack` high. Bytes leave in the order they were written.
- R2: For each forward byte, `pd_out` and `hostack` are set before `nstrobe` falls and stay stable while it is low. `nstrobe` stays low until `busy` is seen high. The next byte does not start until `busy` is seen low.
- R3: In reverse, a falling `nack` stores `pd_in` in the reverse FIFO and `hostack` goes high. `hostack` returns low after `nack` rises. Reads of `0x400` return the stored bytes in order.
- R4: While the reverse FIFO is full, `hostack` stays high after `nack` rises. It drops once a read frees a slot, and no byte is lost.
- R5: `pd_oe` is low whenever `ninit` is low. `ninit` falls only after `pd_oe` has been low for a cycle, and `pd_oe` rises only after `ninit` is high again.
- R6: Control-register write bit 4 requests reverse (1) or forward (0). A turn to reverse waits until the forward FIFO is empty and the current byte's handshake has finished.
- R7: `nselectin` is high while the mode field is `3'b011` and low in any other mode.
- R8: A falling `nfault` in ECP mode sets the request flag (status bit 5) and `irq`, without changing the direction. Writing 1 to control bit 2 clears the flag.
- R9: If `busy` or `nack` is waited for more than `tmo_cycles` clocks, the error flag (status bit 6) is set, `nstrobe` returns high and the engine goes idle. Writing 1 to control bit 3 clears the flag. A `tmo_cycles` of 0 turns the limit off.
- R10: While `dma_act` is high, register writes and reads have no effect.
- R11: A read of `0x402` returns: bit 7 direction (1 reverse), bit 6 error, bit 5 request, bit 4 reverse full, bit 3 reverse empty, bit 2 forward full, bit 1 forward empty, and bit 0 as 0. Each FIFO holds 16 bytes, and a write to a full forward FIFO is dropped.
- R12: Writes to `0x000` or `0x400` do nothing when the mode field is not `3'b011`. A control write sets the mode from bits 7:5. The read data is valid in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Register offset from the port base |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| dma_act | input | 1 | High: the bus cycle belongs to another master, so ignore it |
| tmo_cycles | input | 16 | Handshake wait limit in clocks, 0 = off |
| pd_out | output | 8 | Data bus value the host drives |
| pd_in | input | 8 | Data bus value as sampled |
| pd_oe | output | 1 | Host data bus drive enable |
| nstrobe | output | 1 | Forward byte strobe, active low |
| hostack | output | 1 | Command/data tag (forward) or reverse acknowledge |
| nselectin | output | 1 | Held high in ECP mode |
| ninit | output | 1 | Direction: high forward, low reverse |
| busy | input | 1 | Peripheral forward acknowledge |
| nack | input | 1 | Peripheral reverse strobe, active low |
| nfault | input | 1 | Peripheral request for reverse, active low |
| irq | output | 1 | Request flag |

## Verification
The assertions check the bus-ownership ordering around `ninit` on every cycle. They also check that the forward byte and its tag stay stable under a low strobe, that the strobe is released only after `busy` or a timeout, that the acknowledge rises only after `nack` falls, and that it is held high while the reverse FIFO is full. Data integrity needs the bench's scenarios: byte order and tags across both FIFOs, and the 17-byte reverse burst that must arrive complete through the stall. The same holds for the deferred turnaround while forward bytes remain, the dropped seventeenth forward write, and accesses ignored by mode or by `dma_act`.

// File: rtl/ecp_host_pkg.sv
package ecp_host_pkg;
  localparam int ADDR_W = 11;
  localparam logic [2:0] ECP_MODE = 3'b011;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 11'h000;
  localparam logic [ADDR_W-1:0] OFS_DATA = 11'h400;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 11'h402;

  typedef enum logic [3:0] {
    ST_FIDLE, ST_FLOAD, ST_FSTRB, ST_FWHI, ST_FWLO,
    ST_REL, ST_RIDLE, ST_RWHI, ST_TAKE
  } hs_state_t;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ecp_fifo.sv
module ecp_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/ecp_regs.sv
module ecp_regs
  import ecp_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  input  logic              dma_act,
  input  logic [7:0]        status,
  input  logic [7:0]        rev_dout,
  output logic [2:0]        mode,
  output logic              dir_req,
  output logic              clr_err,
  output logic              clr_irq,
  output logic              fwd_push,
  output logic [8:0]        fwd_din,
  output logic              rev_pop,
  output logic [7:0]        rdata
);
  logic ecp, hit_cmd, hit_data, hit_ctrl;
  logic sel_fifo_q;
  logic [7:0] stat_q;

  assign ecp      = (mode == ECP_MODE);
  assign hit_cmd  = !dma_act && ecp && (addr == OFS_CMD);
  assign hit_data = !dma_act && ecp && (addr == OFS_DATA);
  assign hit_ctrl = !dma_act && (addr == OFS_CTRL);

  assign fwd_push = wr && (hit_cmd || hit_data);
  assign fwd_din  = {hit_data, wdata};
  assign rev_pop  = rd && hit_data;
  assign clr_err  = wr && hit_ctrl && wdata[3];
  assign clr_irq  = wr && hit_ctrl && wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= 3'b000;
      dir_req <= 1'b0;
    end else if (wr && hit_ctrl) begin
      mode    <= wdata[7:5];
      dir_req <= wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_fifo_q <= 1'b0;
      stat_q     <= '0;
    end else if (rd) begin
      sel_fifo_q <= hit_data;
      if (hit_ctrl) stat_q <= status;
    end
  end

  assign rdata = sel_fifo_q ? rev_dout : stat_q;
endmodule

// File: rtl/ecp_hs_fsm.sv
module ecp_hs_fsm
  import ecp_host_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ecp,
  input  logic             dir_req,
  input  logic [TMO_W-1:0] tmo_cycles,
  input  logic             busy_s,
  input  logic             nack_s,
  input  logic             nfault_s,
  input  logic             fwd_empty,
  input  logic [8:0]       fwd_dout,
  input  logic             rev_full,
  input  logic             clr_err,
  input  logic             clr_irq,
  input  logic [7:0]       pd_in,
  output logic             fwd_pop,
  output logic             rev_push,
  output logic [7:0]       rev_din,
  output logic [7:0]       pd_out,
  output logic             pd_oe,
  output logic             nstrobe,
  output logic             hostack,
  output logic             ninit,
  output logic             nselectin,
  output logic             err,
  output logic             irq,
  output logic             tmo_fire
);
  hs_state_t        st;
  logic [TMO_W-1:0] cnt;
  logic             nack_d, nfault_d, waiting;

  assign waiting  = (st == ST_FWHI) || (st == ST_FWLO) || ((st == ST_RWHI) && !nack_s);
  assign tmo_fire = waiting && (tmo_cycles != '0) && (cnt >= tmo_cycles);
  assign fwd_pop  = (st == ST_FIDLE) && ecp && !fwd_empty;
  assign rev_push = (st == ST_RIDLE) && nack_d && !nack_s && !rev_full;
  assign rev_din  = pd_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      nack_d    <= 1'b1;
      nfault_d  <= 1'b1;
      nselectin <= 1'b0;
      irq       <= 1'b0;
    end else begin
      nack_d    <= nack_s;
      nfault_d  <= nfault_s;
      nselectin <= ecp;
      if (clr_irq) irq <= 1'b0;
      if (ecp && nfault_d && !nfault_s) irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_FIDLE;
      cnt     <= '0;
      nstrobe <= 1'b1;
      hostack <= 1'b0;
      ninit   <= 1'b1;
      pd_oe   <= 1'b1;
      pd_out  <= '0;
      err     <= 1'b0;
    end else begin
      if (clr_err) err <= 1'b0;
      case (st)
        ST_FIDLE: begin
          if (fwd_pop) st <= ST_FLOAD;
          else if (ecp && dir_req) begin
            pd_oe <= 1'b0;
            st    <= ST_REL;
          end
        end
        ST_FLOAD: begin
          pd_out  <= fwd_dout[7:0];
          hostack <= fwd_dout[8];
          st      <= ST_FSTRB;
        end
        ST_FSTRB: begin
          nstrobe <= 1'b0;
          cnt     <= '0;
          st      <= ST_FWHI;
        end
        ST_FWHI: begin
          if (busy_s) begin
            nstrobe <= 1'b1;
            cnt     <= '0;
            st      <= ST_FWLO;
          end else if (tmo_fire) begin
            nstrobe <= 1'b1;
            err     <= 1'b1;
            st      <= ST_FIDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_FWLO: begin
          if (!busy_s) st <= ST_FIDLE;
          else if (tmo_fire) begin
            err <= 1'b1;
            st  <= ST_FIDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_REL: begin
          ninit   <= 1'b0;
          hostack <= 1'b0;
          st      <= ST_RIDLE;
        end
        ST_RIDLE: begin
          if (rev_push) begin
            hostack <= 1'b1;
            cnt     <= '0;
            st      <= ST_RWHI;
          end else if (!dir_req || !ecp) begin
            ninit <= 1'b1;
            st    <= ST_TAKE;
          end
        end
        ST_RWHI: begin
          if (nack_s && !rev_full) begin
            hostack <= 1'b0;
            st      <= ST_RIDLE;
          end else if (tmo_fire) begin
            err     <= 1'b1;
            hostack <= 1'b0;
            st      <= ST_RIDLE;
          end else if (!nack_s) cnt <= cnt + 1'b1;
        end
        ST_TAKE: begin
          pd_oe <= 1'b1;
          st    <= ST_FIDLE;
        end
        default: st <= ST_FIDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecp_host_engine.sv
module ecp_host_engine
  import ecp_host_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dma_act,
  input  logic [TMO_W-1:0]  tmo_cycles,
  output logic [7:0]        pd_out,
  input  logic [7:0]        pd_in,
  output logic              pd_oe,
  output logic              nstrobe,
  output logic              hostack,
  output logic              nselectin,
  output logic              ninit,
  input  logic              busy,
  input  logic              nack,
  input  logic              nfault,
  output logic              irq
);
  logic [2:0] mode;
  logic       dir_req, clr_err, clr_irq, err, tmo_fire;
  logic       fwd_push, fwd_pop, fwd_full, fwd_empty;
  logic [8:0] fwd_din, fwd_dout;
  logic       rev_push, rev_pop, rev_full, rev_empty;
  logic [7:0] rev_din, rev_dout, status;
  logic [2:0] sync_q;
  logic       busy_s, nack_s, nfault_s;

  ecp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) i_sync (
    .clk(clk), .rst(rst), .d({busy, nack, nfault}), .q(sync_q)
  );
  assign {busy_s, nack_s, nfault_s} = sync_q;

  ecp_regs i_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .dma_act(dma_act), .status(status), .rev_dout(rev_dout),
    .mode(mode), .dir_req(dir_req), .clr_err(clr_err), .clr_irq(clr_irq),
    .fwd_push(fwd_push), .fwd_din(fwd_din), .rev_pop(rev_pop), .rdata(bus_rdata)
  );

  ecp_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) i_fwd_fifo (
    .clk(clk), .rst(rst), .push(fwd_push), .din(fwd_din), .pop(fwd_pop),
    .dout(fwd_dout), .full(fwd_full), .empty(fwd_empty)
  );

  ecp_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_rev_fifo (
    .clk(clk), .rst(rst), .push(rev_push), .din(rev_din), .pop(rev_pop),
    .dout(rev_dout), .full(rev_full), .empty(rev_empty)
  );

  ecp_hs_fsm #(.TMO_W(TMO_W)) i_fsm (
    .clk(clk), .rst(rst), .ecp(mode == ECP_MODE), .dir_req(dir_req),
    .tmo_cycles(tmo_cycles), .busy_s(busy_s), .nack_s(nack_s), .nfault_s(nfault_s),
    .fwd_empty(fwd_empty), .fwd_dout(fwd_dout), .rev_full(rev_full),
    .clr_err(clr_err), .clr_irq(clr_irq), .pd_in(pd_in),
    .fwd_pop(fwd_pop), .rev_push(rev_push), .rev_din(rev_din),
    .pd_out(pd_out), .pd_oe(pd_oe), .nstrobe(nstrobe), .hostack(hostack),
    .ninit(ninit), .nselectin(nselectin), .err(err), .irq(irq), .tmo_fire(tmo_fire)
  );

  assign status = {!ninit, err, irq, rev_full, rev_empty, fwd_full, fwd_empty, 1'b0};
endmodule

// File: rtl/ecp_host_checker.sv
module ecp_host_checker (
  input logic       clk,
  input logic       rst,
  input logic       ninit,
  input logic       pd_oe,
  input logic       nstrobe,
  input logic       hostack,
  input logic [7:0] pd_out,
  input logic       busy_s,
  input logic       nack_s,
  input logic       tmo_fire,
  input logic       rev_full,
  input logic       irq
);
  a_r5_bus_release: assert property (@(posedge clk) disable iff (rst)
    !ninit |-> !pd_oe);

  a_r5_release_before_turn: assert property (@(posedge clk) disable iff (rst)
    $fell(ninit) |-> !$past(pd_oe));

  a_r5_take_after_turn: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_oe) |-> ninit && $past(ninit));

  a_r2_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (!nstrobe && !$past(nstrobe)) |-> ($stable(pd_out) && $stable(hostack)));

  a_r2_release_on_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(nstrobe) |-> ($past(busy_s) || $past(tmo_fire)));

  a_r3_ack_after_nack: assert property (@(posedge clk) disable iff (rst)
    ($rose(hostack) && !ninit) |-> !$past(nack_s));

  a_r4_stall_full: assert property (@(posedge clk) disable iff (rst)
    (hostack && !ninit && rev_full && nack_s) |=> hostack);

  a_r9_timeout_idle: assert property (@(posedge clk) disable iff (rst)
    tmo_fire |=> nstrobe);

  a_r8_irq_keeps_dir: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $stable(ninit));
endmodule

bind ecp_host_engine ecp_host_checker i_chk (
  .clk(clk), .rst(rst), .ninit(ninit), .pd_oe(pd_oe), .nstrobe(nstrobe),
  .hostack(hostack), .pd_out(pd_out), .busy_s(busy_s), .nack_s(nack_s),
  .tmo_fire(tmo_fire), .rev_full(rev_full), .irq(irq)
);

// File: tb/test_ecp_host_engine.sv
module test_ecp_host_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        dma_act = 1'b0;
  logic [15:0] tmo_cycles = '0;
  logic [7:0]  pd_out, pd_in = '0;
  logic        pd_oe, nstrobe, hostack, nselectin, ninit, irq;
  logic        busy = 1'b0, nack = 1'b1, nfault = 1'b1;

  always #10 clk = ~clk;

  ecp_host_engine i_ecp_host_engine (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_act(dma_act),
    .tmo_cycles(tmo_cycles), .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe),
    .nstrobe(nstrobe), .hostack(hostack), .nselectin(nselectin), .ninit(ninit),
    .busy(busy), .nack(nack), .nfault(nfault), .irq(irq)
  );

  localparam logic [10:0] A_CMD = 11'h000, A_DATA = 11'h400, A_CTRL = 11'h402;

  int n_chk = 0, n_err = 0, n_rx = 0, n_strb = 0, busy_dly = 5;
  logic mon_en = 1'b1;
  logic [8:0] fq[$];
  logic [7:0] rq[$];
  logic [7:0] s;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // driver: expected forward item first, then the register write
  task automatic push_fwd(input logic is_data, input logic [7:0] b);
    fq.push_back({is_data, b});
    bus_write(is_data ? A_DATA : A_CMD, b);
  endtask

  task automatic wait_fwd_drain();
    wait (fq.size() == 0);
    wait (nstrobe == 1'b1 && busy == 1'b0);
    repeat (20) @(negedge clk);
  endtask

  // peripheral reverse sender: expected byte queued first
  task automatic send_rev(input logic [7:0] b);
    rq.push_back(b);
    wait (ninit == 1'b0 && hostack == 1'b0);
    @(negedge clk);
    pd_in = b; nack = 1'b0;
    wait (hostack == 1'b1);
    @(negedge clk);
    nack = 1'b1;
  endtask

  task automatic host_read_rev(input string tag);
    logic [7:0] st, d;
    do bus_read(A_CTRL, st); while (st[3]);
    bus_read(A_DATA, d);
    chk(tag, d, rq.pop_front());
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // forward monitor: peripheral side of the strobe/busy handshake
  initial begin
    forever begin
      @(negedge nstrobe);
      n_strb++;
      if (mon_en) begin
        if (fq.size() == 0) chk("R1 unexpected forward byte", {hostack, pd_out}, 9'h000);
        else chk("R1 forward byte and tag", {hostack, pd_out}, fq.pop_front());
        n_rx++;
        repeat (busy_dly) @(negedge clk);
        chk("R2 strobe held until busy", nstrobe, 1'b0);
        busy = 1'b1;
        wait (nstrobe == 1'b1);
        repeat (2) @(negedge clk);
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // reset state (R11 status layout, R7 mode 000)
    chk("R5 reset ninit", ninit, 1'b1);
    chk("R5 reset pd_oe", pd_oe, 1'b1);
    chk("R2 reset nstrobe", nstrobe, 1'b1);
    chk("R7 nselectin low out of ECP", nselectin, 1'b0);
    bus_read(A_CTRL, s);
    chk("R11 reset status", s, 8'h0A);

    // R12: FIFO offsets inactive outside ECP mode
    bus_write(A_DATA, 8'hAA);
    bus_write(A_CMD, 8'h55);
    repeat (20) @(negedge clk);
    bus_read(A_CTRL, s);
    chk("R12 no push outside ECP", s, 8'h0A);
    chk("R12 no strobe outside ECP", n_strb, 0);

    bus_write(A_CTRL, 8'h60);
    repeat (4) @(negedge clk);
    chk("R7 nselectin high in ECP", nselectin, 1'b1);

    // R10: accesses during dma_act are dropped
    dma_act = 1'b1;
    bus_write(A_DATA, 8'h11);
    bus_write(A_CTRL, 8'h00);
    dma_act = 1'b0;
    repeat (20) @(negedge clk);
    bus_read(A_CTRL, s);
    chk("R10 ignored writes", s, 8'h0A);
    chk("R10 mode kept", nselectin, 1'b1);
    chk("R10 no strobe", n_strb, 0);

    // R1/R2: mixed commands and data
    push_fwd(1'b0, 8'h12);
    push_fwd(1'b1, 8'h34);
    push_fwd(1'b1, 8'hFF);
    push_fwd(1'b0, 8'h00);
    push_fwd(1'b1, 8'hA5);
    wait_fwd_drain();
    chk("R1 forward count", n_rx, 5);

    // R6: turnaround deferred while forward bytes remain
    busy_dly = 30;
    push_fwd(1'b1, 8'h01);
    push_fwd(1'b1, 8'h02);
    push_fwd(1'b0, 8'h03);
    bus_write(A_CTRL, 8'h70);
    bus_read(A_CTRL, s);
    chk("R6 direction still forward", s[7], 1'b0);
    chk("R6 ninit high while pending", ninit, 1'b1);
    wait_fwd_drain();
    busy_dly = 5;
    bus_read(A_CTRL, s);
    chk("R6 reverse after drain", s, 8'h8A);
    chk("R5 ninit low in reverse", ninit, 1'b0);
    chk("R5 bus released in reverse", pd_oe, 1'b0);
    chk("R6 all forward bytes sent", n_rx, 8);

    // R3: reverse bytes
    fork
      begin
        send_rev(8'hC3);
        send_rev(8'h3C);
        send_rev(8'h00);
      end
    join_none
    for (int i = 0; i < 3; i++) host_read_rev("R3 reverse byte");
    repeat (10) @(negedge clk);
    chk("R3 hostack low after handshake", hostack, 1'b0);

    // R4: 17-byte burst against a 16-deep FIFO
    fork
      begin
        for (int i = 0; i < 17; i++) send_rev(8'(8'h40 + i));
      end
    join_none
    do bus_read(A_CTRL, s); while (!s[4]);
    repeat (40) @(negedge clk);
    chk("R4 hostack held while full", hostack, 1'b1);
    chk("R4 peripheral strobe released", nack, 1'b1);
    bus_read(A_CTRL, s);
    chk("R11 reverse full flag", s, 8'h92);
    for (int i = 0; i < 17; i++) host_read_rev("R4 reverse burst byte");
    repeat (10) @(negedge clk);
    chk("R4 hostack low after drain", hostack, 1'b0);

    // R11: forward FIFO fills in reverse, seventeenth write dropped
    for (int i = 0; i < 17; i++) begin
      if (i < 16) fq.push_back({1'b1, 8'(8'h80 + i)});
      bus_write(A_DATA, 8'(8'h80 + i));
    end
    bus_read(A_CTRL, s);
    chk("R11 forward full flag", s, 8'h8C);

    // R8: request from peripheral
    @(negedge clk); nfault = 1'b0;
    repeat (5) @(negedge clk); nfault = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 irq set", irq, 1'b1);
    bus_read(A_CTRL, s);
    chk("R8 request flag, direction kept", s, 8'hAC);
    bus_write(A_CTRL, 8'h74);
    bus_read(A_CTRL, s);
    chk("R8 request cleared", s, 8'h8C);
    chk("R8 irq cleared", irq, 1'b0);

    // back to forward: 16 buffered bytes go out
    bus_write(A_CTRL, 8'h60);
    wait_fwd_drain();
    chk("R5 ninit high in forward", ninit, 1'b1);
    chk("R5 bus taken back", pd_oe, 1'b1);
    chk("R11 sixteen bytes delivered", n_rx, 24);
    bus_read(A_CTRL, s);
    chk("R11 status after drain", s, 8'h0A);

    // R9: timeout on missing busy
    tmo_cycles = 16'd20;
    mon_en = 1'b0;
    bus_write(A_DATA, 8'h5A);
    repeat (100) @(negedge clk);
    bus_read(A_CTRL, s);
    chk("R9 error flag set", s, 8'h4A);
    chk("R9 strobe released", nstrobe, 1'b1);
    bus_write(A_CTRL, 8'h68);
    bus_read(A_CTRL, s);
    chk("R9 error cleared", s, 8'h0A);
    mon_en = 1'b1;
    tmo_cycles = '0;

    push_fwd(1'b1, 8'h77);
    wait_fwd_drain();
    chk("R1 forward after timeout", n_rx, 25);

    report();
  end
endmodule